// File: doc/BRIEF.md
# Dual-Channel DAC Command Decoder

This block sits behind a serial front end that has already collected a 24-bit command word. On a single-cycle strobe it splits the word into a control nibble, an address nibble and a 14-bit code. It then updates the digital state of two converter channels. Each channel keeps a staging code and an active code that move independently, along with a power-down flag and a speed flag. Each channel's active code, power-down flag and fast/slow flag are brought out as registered outputs.

A shared forced-zero output tells the analog side to hold both outputs at ground. It is high while an asynchronous clear is active. It is also high for a parameterised number of system clocks after reset, which models the hold that follows power-on. Clear zeroes every code register at once, without waiting for the clock.

Top module: `dac_cmd_decoder`

## Requirements
- R1: The command word is read as control = bits 23:20, address = bits 19:16 and code = bits 15:2, with the most significant code bit at bit 15. Bits 1:0 have no effect on any output.
- R2: Address 0000 targets channel A, 0001 targets channel B and 1111 targets both. A command with any other address changes no register.
- R3: Control 0000 writes the code into the targeted staging register(s). Active codes stay as they were.
- R4: Control 0001 copies each targeted staging register into its active register and clears that channel's power-down flag.
- R5: Control 0010 writes the code into the targeted staging register(s). It then loads every channel's active register, using the new code for targeted channels and the stored staging value for the others, and clears every power-down flag. A targeted channel's active register receives the new code, not its previous staging value.
- R6: Control 0011 writes the code into both the staging and active registers of each targeted channel and clears its power-down flag.
- R7: Control 0100 sets the power-down flag, 0101 selects fast mode and 0110 selects slow mode, on the targeted channel(s). Setting power-down leaves the speed flag unchanged (fast = 1, slow = 0).
- R8: Control 1111 and every control value not listed above change no register.
- R9: After reset, both active codes are zero, both channels are powered (power-down = 0) and slow (fast = 0). Forced-zero is high and is released once POR_CYCLES clocks have passed after reset release.
- R10: While clear (active low) is asserted, all staging and active codes read zero without waiting for a clock edge, and forced-zero is high. Power and speed flags are kept. Forced-zero drops when clear is released.
- R11: When the strobe is low, no output changes, whatever the command word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_n | input | 1 | Asynchronous active-low clear of all codes |
| cmd_vld | input | 1 | One-cycle strobe marking a valid command word |
| cmd_word | input | 24 | Command word: control, address, code, two ignored bits |
| code_a | output | 14 | Active code of channel A |
| code_b | output | 14 | Active code of channel B |
| pd_a | output | 1 | Channel A powered down |
| pd_b | output | 1 | Channel B powered down |
| fast_a | output | 1 | Channel A in fast mode (0 = slow) |
| fast_b | output | 1 | Channel B in fast mode (0 = slow) |
| zero_force | output | 1 | Outputs must be held at zero (clear or power-on hold) |

## Verification
The staging registers have no port of their own. Staging contents are seen only through a later promote, so the bench pairs each staging write with a promote command that shows the stored value. It also puts a staging write of a different code directly before a load-and-promote-all command, to prove the active register takes the fresh code. The effect of clear on staging is seen the same way: a promote after clear release must return zero.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  localparam int CODE_W  = 14;
  localparam int CTRL_W  = 4;
  localparam int ADDR_W  = 4;
  localparam int PAD_W   = 2;
  localparam int WORD_W  = CTRL_W + ADDR_W + CODE_W + PAD_W;
  localparam int NCH     = 2;

  localparam logic [ADDR_W-1:0] ADDR_ALL = '1;

  typedef enum logic [CTRL_W-1:0] {
    OP_STAGE     = 4'h0,
    OP_PROMOTE   = 4'h1,
    OP_STAGE_ALL = 4'h2,
    OP_LOAD_GO   = 4'h3,
    OP_SLEEP     = 4'h4,
    OP_FAST      = 4'h5,
    OP_SLOW      = 4'h6,
    OP_NOP       = 4'hF
  } ctrl_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic [PAD_W-1:0]  pad;
  } cmd_t;

  typedef struct packed {
    logic ld_stage;
    logic act_data;
    logic act_stage;
    logic wake;
    logic sleep;
    logic go_fast;
    logic go_slow;
  } chan_op_t;

endpackage

// File: rtl/dac_cmd_split.sv
module dac_cmd_split
  import dac_cmd_pkg::*;
(
  input  logic                       vld,
  input  logic [WORD_W-1:0]          word,
  output chan_op_t [NCH-1:0]         ops,
  output logic [CODE_W-1:0]          code
);

  cmd_t             f;
  logic [NCH-1:0]   sel;
  logic             addr_ok;
  logic             unused_pad;

  assign f          = cmd_t'(word);
  assign code       = f.code;
  assign unused_pad = ^f.pad;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sel[i] = (f.addr == ADDR_W'(i)) || (f.addr == ADDR_ALL);
    end
    addr_ok = |sel;
  end

  always_comb begin
    ops = '0;
    if (vld && addr_ok) begin
      for (int i = 0; i < NCH; i++) begin
        case (f.ctrl)
          OP_STAGE: begin
            ops[i].ld_stage = sel[i];
          end
          OP_PROMOTE: begin
            ops[i].act_stage = sel[i];
            ops[i].wake      = sel[i];
          end
          OP_STAGE_ALL: begin
            ops[i].ld_stage  = sel[i];
            ops[i].act_data  = sel[i];
            ops[i].act_stage = !sel[i];
            ops[i].wake      = 1'b1;
          end
          OP_LOAD_GO: begin
            ops[i].ld_stage = sel[i];
            ops[i].act_data = sel[i];
            ops[i].wake     = sel[i];
          end
          OP_SLEEP: ops[i].sleep   = sel[i];
          OP_FAST:  ops[i].go_fast = sel[i];
          OP_SLOW:  ops[i].go_slow = sel[i];
          default:  ops[i] = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/dac_chan_state.sv
module dac_chan_state
  import dac_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               code_rst_n,
  input  chan_op_t           op,
  input  logic [CODE_W-1:0]  code_in,
  output logic [CODE_W-1:0]  active,
  output logic               pd,
  output logic               fast
);

  logic [CODE_W-1:0] stage_q, stage_d;
  logic [CODE_W-1:0] act_q, act_d;
  logic              pd_q, pd_d;
  logic              fast_q, fast_d;
  logic              stage_en, act_en, pd_en, fast_en;

  always_comb begin
    stage_en = op.ld_stage;
    stage_d  = code_in;
    act_en   = op.act_data | op.act_stage;
    act_d    = op.act_data ? code_in : stage_q;
    pd_en    = op.sleep | op.wake;
    pd_d     = op.sleep;
    fast_en  = op.go_fast | op.go_slow;
    fast_d   = op.go_fast;
  end

  always_ff @(posedge clk or negedge code_rst_n) begin
    if (!code_rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (act_en)   act_q   <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      if (pd_en)   pd_q   <= pd_d;
      if (fast_en) fast_q <= fast_d;
    end
  end

  assign active = act_q;
  assign pd     = pd_q;
  assign fast   = fast_q;

  AST_FRESH_CODE: assert property (@(posedge clk) disable iff (!code_rst_n)
    op.act_data |=> act_q == $past(code_in)); // R5

  AST_SLEEP_KEEPS_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    (op.sleep && !op.go_fast && !op.go_slow) |=> pd_q && $stable(fast_q)); // R7

endmodule

// File: rtl/dac_por_hold.sv
module dac_por_hold #(
  parameter int POR_CYCLES = 38
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n,
  output logic busy
);

  localparam int              CNT_W    = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_CYCLES - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

  always_comb begin
    cnt_en = busy_q;
    cnt_d  = cnt_q + 1'b1;
    busy_d = (cnt_q != POR_LAST);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  AST_POR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_q |-> cnt_q <= POR_LAST); // R9

endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dac_cmd_pkg::*;
#(
  parameter int POR_CYCLES = 38
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_n,
  input  logic                 cmd_vld,
  input  logic [WORD_W-1:0]    cmd_word,
  output logic [CODE_W-1:0]    code_a,
  output logic [CODE_W-1:0]    code_b,
  output logic                 pd_a,
  output logic                 pd_b,
  output logic                 fast_a,
  output logic                 fast_b,
  output logic                 zero_force
);

  logic                     rst_sync_n;
  logic                     por_busy;
  logic                     code_rst_n;
  chan_op_t [NCH-1:0]       ops;
  logic [CODE_W-1:0]        code_fld;
  logic [NCH-1:0][CODE_W-1:0] act;
  logic [NCH-1:0]           pdv;
  logic [NCH-1:0]           fastv;

  dac_por_hold #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .busy       (por_busy)
  );

  assign code_rst_n = rst_sync_n & clr_n;

  dac_cmd_split u_split (
    .vld  (cmd_vld),
    .word (cmd_word),
    .ops  (ops),
    .code (code_fld)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dac_chan_state u_ch (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .code_rst_n (code_rst_n),
      .op         (ops[g]),
      .code_in    (code_fld),
      .active     (act[g]),
      .pd         (pdv[g]),
      .fast       (fastv[g])
    );
  end

  assign code_a     = act[0];
  assign code_b     = act[1];
  assign pd_a       = pdv[0];
  assign pd_b       = pdv[1];
  assign fast_a     = fastv[0];
  assign fast_b     = fastv[1];
  assign zero_force = por_busy | ~clr_n;

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!code_rst_n)
    !cmd_vld |=> $stable(code_a) && $stable(code_b) && $stable(pd_a) && $stable(pd_b)
                 && $stable(fast_a) && $stable(fast_b)); // R11

  AST_BAD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!code_rst_n)
    (cmd_vld && cmd_word[19:16] != 4'h0 && cmd_word[19:16] != 4'h1 && cmd_word[19:16] != 4'hF)
    |=> $stable(code_a) && $stable(code_b) && $stable(pd_a) && $stable(pd_b)
        && $stable(fast_a) && $stable(fast_b)); // R2

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!code_rst_n)
    (cmd_vld && cmd_word[23:20] > 4'h6)
    |=> $stable(code_a) && $stable(code_b) && $stable(pd_a) && $stable(pd_b)
        && $stable(fast_a) && $stable(fast_b)); // R8

  AST_LOAD_GO_A: assert property (@(posedge clk) disable iff (!code_rst_n)
    (cmd_vld && cmd_word[23:20] == 4'h3 && (cmd_word[19:16] == 4'h0 || cmd_word[19:16] == 4'hF))
    |=> code_a == $past(cmd_word[15:2]) && !pd_a); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_n |-> code_a == '0 && code_b == '0 && zero_force); // R10

endmodule

// File: tb/sim_dac_cmd_decoder.sv
`timescale 1ns/1ps
module sim_dac_cmd_decoder;

  localparam int POR = 38;
  localparam int NV  = 21;

  logic        clk = 1'b0;
  logic        rst_n, clr_n, cmd_vld;
  logic [23:0] cmd_word;
  logic [13:0] code_a, code_b;
  logic        pd_a, pd_b, fast_a, fast_b, zero_force;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dac_cmd_decoder #(.POR_CYCLES(POR)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmd_vld(cmd_vld), .cmd_word(cmd_word),
    .code_a(code_a), .code_b(code_b), .pd_a(pd_a), .pd_b(pd_b),
    .fast_a(fast_a), .fast_b(fast_b), .zero_force(zero_force)
  );

  // {word, expected code_a, expected code_b, pd_a, pd_b, fast_a, fast_b}
  localparam logic [55:0] VEC [NV] = '{
    {4'h0,4'h0,14'h1111,2'b11, 14'h0000,14'h0000,4'b0000}, // R3 R1 stage A
    {4'h1,4'h0,14'h0000,2'b00, 14'h1111,14'h0000,4'b0000}, // R4 promote A
    {4'h0,4'h1,14'h2222,2'b01, 14'h1111,14'h0000,4'b0000}, // R3 stage B
    {4'h0,4'h0,14'h0333,2'b00, 14'h1111,14'h0000,4'b0000}, // R3 active A kept
    {4'h2,4'h1,14'h3ABC,2'b10, 14'h0333,14'h3ABC,4'b0000}, // R5 stage B, promote all
    {4'h4,4'hF,14'h0000,2'b00, 14'h0333,14'h3ABC,4'b1100}, // R7 R2 sleep both
    {4'h5,4'h0,14'h0000,2'b00, 14'h0333,14'h3ABC,4'b1110}, // R7 fast A
    {4'h3,4'h1,14'h0055,2'b00, 14'h0333,14'h0055,4'b1010}, // R6 load+go B
    {4'h1,4'hF,14'h0000,2'b00, 14'h0333,14'h0055,4'b0010}, // R4 promote both
    {4'h4,4'h0,14'h0000,2'b00, 14'h0333,14'h0055,4'b1010}, // R7 sleep keeps fast
    {4'h6,4'h0,14'h0000,2'b00, 14'h0333,14'h0055,4'b1000}, // R7 slow A
    {4'h5,4'hF,14'h0000,2'b00, 14'h0333,14'h0055,4'b1011}, // R7 fast both
    {4'h3,4'h2,14'h1FFF,2'b00, 14'h0333,14'h0055,4'b1011}, // R2 reserved address
    {4'h7,4'h0,14'h2AAA,2'b00, 14'h0333,14'h0055,4'b1011}, // R8 reserved control
    {4'hF,4'h0,14'h3FFF,2'b00, 14'h0333,14'h0055,4'b1011}, // R8 no-op
    {4'h8,4'hF,14'h1555,2'b00, 14'h0333,14'h0055,4'b1011}, // R8 reserved control
    {4'h0,4'h0,14'h3FFF,2'b00, 14'h0333,14'h0055,4'b1011}, // R3 stage A
    {4'h2,4'h0,14'h0001,2'b00, 14'h0001,14'h0055,4'b0011}, // R5 fresh code wins
    {4'h3,4'hF,14'h3FFF,2'b00, 14'h3FFF,14'h3FFF,4'b0011}, // R6 load+go both
    {4'h2,4'hF,14'h0A0A,2'b00, 14'h0A0A,14'h0A0A,4'b0011}, // R5 both targeted
    {4'h2,4'h9,14'h1234,2'b00, 14'h0A0A,14'h0A0A,4'b0011}  // R2 reserved address
  };
  localparam int VREQ [NV] = '{3,4,3,3,5,7,7,6,4,7,7,7,2,8,8,8,3,5,6,5,2};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {code_a, code_b, pd_a, pd_b, fast_a, fast_b};
  endfunction

  task automatic send(logic [23:0] w);
    @(negedge clk);
    cmd_word = w;
    cmd_vld  = 1'b1;
    @(negedge clk);
    cmd_vld  = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; cmd_vld = 1'b0; cmd_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 reset state", outs(), 32'h0);
    chk("R9 hold active", {31'b0, zero_force}, 32'd1);
    repeat (POR / 2) @(negedge clk);
    chk("R9 hold mid", {31'b0, zero_force}, 32'd1);
    repeat (POR) @(negedge clk);
    chk("R9 hold released", {31'b0, zero_force}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][55:32]);
      chk($sformatf("R%0d vector %0d", VREQ[i], i), outs(), VEC[i][31:0]);
    end

    // R11: command present without strobe
    @(negedge clk);
    cmd_word = {4'h3, 4'hF, 14'h1234, 2'b00};
    repeat (5) @(negedge clk);
    chk("R11 no strobe", outs(), {14'h0A0A, 14'h0A0A, 4'b0011});

    // R10: asynchronous clear between edges
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    chk("R10 codes cleared", outs(), {14'h0, 14'h0, 4'b0011});
    chk("R10 force high", {31'b0, zero_force}, 32'd1);
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    #1;
    chk("R10 force released", {31'b0, zero_force}, 32'd0);
    send({4'h1, 4'hF, 14'h0, 2'b00});
    chk("R10 staging cleared", outs(), {14'h0, 14'h0, 4'b0011});

    // R1: low pad bits alone differ
    send({4'h3, 4'h0, 14'h2001, 2'b11});
    chk("R1 code field", outs(), {14'h2001, 14'h0, 4'b0011});

    // R9: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 rerun reset", outs(), 32'h0);
    chk("R9 rerun force", {31'b0, zero_force}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule